// File: doc/BRIEF.md
# Page-Mode ROM Read Controller

This controller sits between a synchronous host and an external asynchronous read-only memory that supports fast reads within a page. The host gives a byte address with a request. The controller drives the memory address lines, chip enable and output enable. It waits a counted number of clock cycles and then registers the data bus. The result goes back to the host with a one-cycle valid pulse.

The memory has a 16-bit word mode and an 8-bit byte mode. In byte mode the controller drives the lowest address bit out on the memory's top data pin, and it returns only the low eight data lines.

The controller keeps chip enable asserted between reads. It remembers which page is open, where a page is eight words selected by the word address bits from bit 3 upward. A read that lands in the open page, in the same mode, waits only the short in-page count. Every other read waits the full random-access count. Chip enable is dropped after a set number of idle cycles, and the page is then closed.

Top module: `pmrom_reader`

## Requirements
- R1: After reset `rd_ready` is 1, `rd_valid` is 0, and `mem_ce_n`, `mem_oe_n` are both 1.
- R2: On an accepted request, `mem_addr` takes `rd_addr[ADDR_W:1]`. `mem_lsb_oe` is 1 only in byte mode (`byte_mode`=1), and then `mem_lsb_o` equals `rd_addr[0]`. `mem_ce_n` and `mem_oe_n` are 0.
- R3: In word mode, `rd_data` is the full 16-bit `mem_dq` sampled at the end of the wait.
- R4: In byte mode, `rd_data` is `{8'h00, mem_dq[7:0]}`, and bits 15:8 of the bus are ignored.
- R5: A page miss raises `rd_valid` in the cycle after the MISS_WAIT-th rising edge that follows the accepting edge. The first read after reset is a miss.
- R6: A request is a hit, and takes HIT_WAIT edges instead, when chip enable is still held, the mode matches the previous read, and the word address bits from 3 upward equal those of the previous read.
- R7: While a read is in progress, `mem_addr` and `mem_lsb_o` stay stable, `mem_ce_n` stays 0, and `rd_ready` is 0.
- R8: After IDLE_REL consecutive idle edges with no accepted request, `mem_ce_n` and `mem_oe_n` return to 1, and the next read is a miss. A request on the IDLE_REL-th idle edge is still a hit.
- R9: A request whose mode differs from the previous read is a miss, even within the same page.
- R10: `rd_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 = 8-bit reads, 0 = 16-bit reads |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W+1 | Byte address; bit 0 is unused in word mode |
| rd_ready | output | 1 | Controller can accept a request |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` |
| mem_addr | output | ADDR_W | Memory word address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lsb_o | output | 1 | Lowest byte-address bit for the top data pin |
| mem_lsb_oe | output | 1 | Drive enable for the top data pin |
| mem_dq | input | 16 | Memory data bus |

## Verification
The accepting edge is edge 0. The bus is registered on edge MISS_WAIT or HIT_WAIT, and `rd_valid` is high in the cycle that follows. The bench therefore counts rising edges from the accepting edge and samples 1 ns after each edge until the strobe appears. The count must equal the wait that the bench's own open-page tracker predicts.

Chip-enable release is checked at IDLE_REL-1 and at IDLE_REL idle edges, each sampled just after the edge. A request placed on the last idle edge must still see the short wait.

// File: rtl/pmrom_reader.sv
module pmrom_reader #(
  parameter int ADDR_W    = 21,
  parameter int MISS_WAIT = 10,
  parameter int HIT_WAIT  = 3,
  parameter int IDLE_REL  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              rd_req,
  input  logic [ADDR_W:0]   rd_addr,
  output logic              rd_ready,
  output logic [15:0]       rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_lsb_o,
  output logic              mem_lsb_oe,
  input  logic [15:0]       mem_dq
);
  localparam int PG_W  = 3;
  localparam int CNT_W = $clog2(MISS_WAIT + 1);
  localparam int IDL_W = $clog2(IDLE_REL + 1);

  logic             busy;
  logic             mode_q;
  logic [CNT_W-1:0] cnt;
  logic [IDL_W-1:0] idle_cnt;

  wire accept = rd_req & ~busy;
  wire hit    = ~mem_ce_n & (mode_q == byte_mode) &
                (mem_addr[ADDR_W-1:PG_W] == rd_addr[ADDR_W:PG_W+1]);

  assign rd_ready   = ~busy;
  assign mem_lsb_oe = mode_q & ~mem_ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      mode_q    <= 1'b0;
      cnt       <= '0;
      idle_cnt  <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_addr  <= '0;
      mem_lsb_o <= 1'b0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        mem_addr  <= rd_addr[ADDR_W:1];
        mem_lsb_o <= rd_addr[0];
        mode_q    <= byte_mode;
        mem_ce_n  <= 1'b0;
        mem_oe_n  <= 1'b0;
        idle_cnt  <= '0;
        cnt       <= hit ? CNT_W'(HIT_WAIT - 1) : CNT_W'(MISS_WAIT - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy     <= 1'b0;
          rd_valid <= 1'b1;
          rd_data  <= mode_q ? {8'h00, mem_dq[7:0]} : mem_dq;
          idle_cnt <= '0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (!mem_ce_n) begin
        if (idle_cnt == IDL_W'(IDLE_REL - 1)) begin
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end

  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(mem_addr) && $stable(mem_lsb_o)));
  assert_ce_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready |-> !mem_ce_n);
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> (rd_ready && !rd_valid));
endmodule

// File: tb/sim_pmrom_reader.sv
module sim_pmrom_reader;
  localparam int AW = 6, MW = 25, HW = 8, IR = 4;

  logic clk = 0, rst_n = 0, byte_mode = 0, rd_req = 0;
  logic [AW:0] rd_addr = '0;
  logic rd_ready, rd_valid, mem_ce_n, mem_oe_n, mem_lsb_o, mem_lsb_oe;
  logic [15:0] rd_data, mem_dq;
  logic [AW-1:0] mem_addr;
  int tests = 0, fails = 0;
  bit open = 0, last_mode = 0;
  int last_page = -1;

  always #2 clk = ~clk;

  pmrom_reader #(.ADDR_W(AW), .MISS_WAIT(MW), .HIT_WAIT(HW), .IDLE_REL(IR)) u0 (
    .clk, .rst_n, .byte_mode, .rd_req, .rd_addr, .rd_ready, .rd_data, .rd_valid,
    .mem_addr, .mem_ce_n, .mem_oe_n, .mem_lsb_o, .mem_lsb_oe, .mem_dq);

  function automatic logic [15:0] wv(int w);
    return 16'((w * 16'h9E37) ^ 16'h5A5A);
  endfunction

  always_comb begin
    logic [15:0] w;
    w = wv(int'(mem_addr));
    if (mem_ce_n || mem_oe_n) mem_dq = 16'hDEAD;
    else if (mem_lsb_oe) mem_dq = {8'hA5, mem_lsb_o ? w[15:8] : w[7:0]};
    else mem_dq = w;
  end

  task automatic chk(bit ok, string r, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic rd(int a, bit bm);
    int lat, pg, expw;
    logic [15:0] w, ed;
    pg = a >> 4;
    expw = (open && pg == last_page && bm == last_mode) ? HW : MW;
    chk(rd_ready == 1, "R7 ready before request", rd_ready, 1);
    rd_req = 1; rd_addr = (AW+1)'(a); byte_mode = bm;
    @(posedge clk); #1 rd_req = 0;
    chk(mem_addr == AW'(a >> 1), "R2 address", mem_addr, a >> 1);
    chk(mem_lsb_oe == bm, "R2 lsb enable", mem_lsb_oe, bm);
    if (bm) chk(mem_lsb_o == a[0], "R2 lsb value", mem_lsb_o, a[0]);
    chk(!mem_ce_n && !mem_oe_n && !rd_ready, "R7 enables during read", {mem_ce_n, mem_oe_n, rd_ready}, 0);
    lat = 0;
    do begin @(posedge clk); #1 lat++; end while (!rd_valid && lat < 100);
    chk(lat == expw, expw == HW ? "R6 hit latency" : "R5 R9 miss latency", lat, expw);
    w = wv(a >> 1);
    ed = bm ? {8'h00, (a & 1) ? w[15:8] : w[7:0]} : w;
    chk(rd_data == ed, bm ? "R4 byte data" : "R3 word data", rd_data, ed);
    @(posedge clk); #1;
    chk(rd_valid == 0, "R10 single pulse", rd_valid, 0);
    open = 1; last_page = pg; last_mode = bm;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(rd_ready && !rd_valid && mem_ce_n && mem_oe_n, "R1 reset state",
        {rd_ready, rd_valid, mem_ce_n, mem_oe_n}, 4'b1011);
    for (int w = 0; w < (1 << AW); w++) rd(w * 2, 0);
    for (int b = 0; b < (2 << AW); b++) rd(b, 1);
    rd(5, 1);
    repeat (IR - 2) @(posedge clk);
    #1 chk(mem_ce_n == 0, "R8 held before limit", mem_ce_n, 0);
    rd(9, 1);
    repeat (IR - 1) @(posedge clk);
    #1 chk(mem_ce_n && mem_oe_n, "R8 released", {mem_ce_n, mem_oe_n}, 2'b11);
    open = 0;
    rd(10, 1);
    rd(12, 0);
    rd(2, 1);
    rd(40, 0);
    rd(44, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule